// File: doc/BRIEF.md
# Condition Field Register File

This block holds a small bank of condition registers. Each register can be read or written as one full word or as any subset of its 4-bit condition fields. A binary index picks the register. A unary (one-hot or multi-hot) mask picks the fields inside it, and each mask bit acts as the write enable for its own field. Several read ports and several write ports work in the same cycle. Reads are combinational. Writes take effect at the clock edge.

Field-granular access is made on top of the full-width ports by small adapters. On a read, the gather adapter zeroes every field the mask leaves out. It also folds the remaining field slots together with OR, so a single selected field appears directly on a 4-bit output. On a write, the scatter adapter can copy one 4-bit value into every field the mask selects, so a single field can be written without the caller placing it in the word.

Top module: `crf_file`

## Requirements
- R1: After reset every register holds zero, and every read port returns zero under any mask until a write lands.
- R2: A write with mask 8'hFF and word mode (`wr_fmode`=0) stores the whole 32-bit `wr_data` word. A following read of the same index with mask 8'hFF returns that word.
- R3: Mask bit i enables bits [4i+3:4i] only, with bit 7 the most significant field. Fields whose mask bit is 0 keep their old contents.
- R4: On a read, every 4-bit slot of `rd_data` whose mask bit is 0 is zero. Every slot whose mask bit is 1 carries the stored field.
- R5: `rd_fld` of each read port is the bitwise OR of the eight 4-bit slots of that port's `rd_data`. With a single mask bit set, it equals the selected field.
- R6: With `wr_fmode`=1, bits [3:0] of `wr_data` are written into every field selected by the mask. Bits [31:4] are ignored.
- R7: When two or more write ports write the same field of the same register in one cycle, the highest-numbered port's value is stored. Writes to different fields of one register from different ports all take effect.
- R8: Reads are combinational. In the cycle a write is presented, a read of the same register returns the contents from before the write.
- R9: A write port whose mask is all zero changes nothing, whatever its data, index or mode.
- R10: The four read ports select registers and masks independently within one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_idx | input | 16 | Register index per read port, 4 bits each, port 0 in the low bits |
| rd_mask | input | 32 | Field mask per read port, 8 bits each |
| rd_data | output | 128 | Masked word per read port, 32 bits each |
| rd_fld | output | 16 | OR of the masked field slots per read port, 4 bits each |
| wr_idx | input | 12 | Register index per write port, 4 bits each |
| wr_mask | input | 24 | Field write enables per write port, 8 bits each |
| wr_data | input | 96 | Write data per write port, 32 bits each |
| wr_fmode | input | 3 | Per write port: 0 = word data, 1 = broadcast bits [3:0] into the selected fields |

## Verification
On every cycle, the assertions check the relations that hold among the ports:
- unselected read slots are zero;
- a single-field read shows up unchanged on the field output;
- the register file reads zero after reset;
- a cycle with no write enable leaves a steady read steady;
- a full-word write from the highest port reads back on the next cycle.

Only the bench's scenarios can show the rest:
- contents are kept across partial-field writes;
- broadcast field writes land where the mask says;
- same-field conflicts resolve by port priority while different-field writes merge;
- reads in the write cycle return old data.

// File: rtl/crf_pkg.sv
package crf_pkg;
   localparam int unsigned CRF_FIELD_W   = 4;
   localparam int unsigned CRF_NFIELDS   = 8;
   localparam int unsigned CRF_NREGS     = 16;
   localparam int unsigned CRF_RD_PORTS  = 4;
   localparam int unsigned CRF_WR_PORTS  = 3;

   typedef enum logic {
      WMODE_WORD  = 1'b0,
      WMODE_FIELD = 1'b1
   } crf_wmode_e;
endpackage

// File: rtl/crf_rd_adapter.sv
module crf_rd_adapter #(
   parameter int unsigned NF = 8,
   parameter int unsigned FW = 4,
   localparam int unsigned WW = NF * FW
) (
   input  logic [WW-1:0] word_i,
   input  logic [NF-1:0] mask_i,
   output logic [WW-1:0] data_o,
   output logic [FW-1:0] fld_o
);
   genvar f;
   generate
      for (f = 0; f < NF; f++) begin : g_slot
         assign data_o[f*FW +: FW] = mask_i[f] ? word_i[f*FW +: FW] : '0;
      end
   endgenerate

   always_comb begin
      fld_o = '0;
      for (int i = 0; i < NF; i++) begin
         fld_o = fld_o | data_o[i*FW +: FW];
      end
   end
endmodule

// File: rtl/crf_wr_adapter.sv
module crf_wr_adapter #(
   parameter int unsigned NF       = 8,
   parameter int unsigned FW       = 4,
   parameter bit          FIELD_EN = 1'b1,
   localparam int unsigned WW      = NF * FW
) (
   input  logic [WW-1:0] data_i,
   input  logic          fmode_i,
   output logic [WW-1:0] data_o
);
   import crf_pkg::*;
   generate
      if (FIELD_EN) begin : g_scatter
         crf_wmode_e mode;
         assign mode   = crf_wmode_e'(fmode_i);
         assign data_o = (mode == WMODE_FIELD) ? {NF{data_i[FW-1:0]}} : data_i;
      end else begin : g_word_only
         logic unused_mode;
         assign unused_mode = fmode_i;
         assign data_o      = data_i;
      end
   endgenerate
endmodule

// File: rtl/crf_store.sv
module crf_store #(
   parameter int unsigned NREGS = 16,
   parameter int unsigned NF    = 8,
   parameter int unsigned FW    = 4,
   parameter int unsigned NWR   = 3,
   localparam int unsigned WW   = NF * FW,
   localparam int unsigned IW   = $clog2(NREGS)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NWR*IW-1:0]        w_idx,
   input  logic [NWR*NF-1:0]        w_mask,
   input  logic [NWR*WW-1:0]        w_data,
   output logic [NREGS-1:0][WW-1:0] regs_o
);
   logic [NREGS-1:0][WW-1:0] q;
   logic [NREGS-1:0][WW-1:0] nxt;

   // Ports applied in ascending order: the highest port's field lands last.
   always_comb begin
      nxt = q;
      for (int p = 0; p < NWR; p++) begin
         for (int f = 0; f < NF; f++) begin
            if (w_mask[p*NF + f] && (32'(w_idx[p*IW +: IW]) < NREGS)) begin
               nxt[w_idx[p*IW +: IW]][f*FW +: FW] = w_data[p*WW + f*FW +: FW];
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else        q <= nxt;
   end

   assign regs_o = q;
endmodule

// File: rtl/crf_file.sv
module crf_file #(
   parameter int unsigned NREGS    = crf_pkg::CRF_NREGS,
   parameter int unsigned NF       = crf_pkg::CRF_NFIELDS,
   parameter int unsigned FW       = crf_pkg::CRF_FIELD_W,
   parameter int unsigned NRD      = crf_pkg::CRF_RD_PORTS,
   parameter int unsigned NWR      = crf_pkg::CRF_WR_PORTS,
   parameter bit          FIELD_EN = 1'b1,
   localparam int unsigned WW      = NF * FW,
   localparam int unsigned IW      = $clog2(NREGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NRD*IW-1:0] rd_idx,
   input  logic [NRD*NF-1:0] rd_mask,
   output logic [NRD*WW-1:0] rd_data,
   output logic [NRD*FW-1:0] rd_fld,
   input  logic [NWR*IW-1:0] wr_idx,
   input  logic [NWR*NF-1:0] wr_mask,
   input  logic [NWR*WW-1:0] wr_data,
   input  logic [NWR-1:0]    wr_fmode
);
   initial begin
      assert (NREGS >= 2) else $fatal(1, "crf_file: NREGS must be at least 2");
      assert (NF >= 1 && FW >= 1) else $fatal(1, "crf_file: field geometry empty");
      assert (NRD >= 1 && NWR >= 1) else $fatal(1, "crf_file: need read and write ports");
   end

   logic [NWR*WW-1:0]        w_eff;
   logic [NREGS-1:0][WW-1:0] regs;

   genvar p;
   generate
      for (p = 0; p < NWR; p++) begin : g_wr
         crf_wr_adapter #(.NF(NF), .FW(FW), .FIELD_EN(FIELD_EN)) u_wad (
            .data_i  (wr_data[p*WW +: WW]),
            .fmode_i (wr_fmode[p]),
            .data_o  (w_eff[p*WW +: WW])
         );
      end
   endgenerate

   crf_store #(.NREGS(NREGS), .NF(NF), .FW(FW), .NWR(NWR)) u_store (
      .clk    (clk),
      .rst_n  (rst_n),
      .w_idx  (wr_idx),
      .w_mask (wr_mask),
      .w_data (w_eff),
      .regs_o (regs)
   );

   generate
      for (p = 0; p < NRD; p++) begin : g_rd
         logic [WW-1:0] word;
         assign word = (32'(rd_idx[p*IW +: IW]) < NREGS) ? regs[rd_idx[p*IW +: IW]] : '0;
         crf_rd_adapter #(.NF(NF), .FW(FW)) u_rad (
            .word_i (word),
            .mask_i (rd_mask[p*NF +: NF]),
            .data_o (rd_data[p*WW +: WW]),
            .fld_o  (rd_fld[p*FW +: FW])
         );
      end
   endgenerate
endmodule

// File: rtl/crf_chk.sv
module crf_chk #(
   parameter int unsigned NREGS = 16,
   parameter int unsigned NF    = 8,
   parameter int unsigned FW    = 4,
   parameter int unsigned NRD   = 4,
   parameter int unsigned NWR   = 3,
   localparam int unsigned WW   = NF * FW,
   localparam int unsigned IW   = $clog2(NREGS),
   localparam int unsigned LP   = NWR - 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NRD*IW-1:0] rd_idx,
   input logic [NRD*NF-1:0] rd_mask,
   input logic [NRD*WW-1:0] rd_data,
   input logic [NRD*FW-1:0] rd_fld,
   input logic [NWR*IW-1:0] wr_idx,
   input logic [NWR*NF-1:0] wr_mask,
   input logic [NWR*WW-1:0] wr_data,
   input logic [NWR-1:0]    wr_fmode
);
   genvar rp, f;
   generate
      for (rp = 0; rp < NRD; rp++) begin : g_rp
         // R1
         reset_zero_chk: assert property (@(posedge clk)
            !rst_n |=> rd_data[rp*WW +: WW] == '0);
         for (f = 0; f < NF; f++) begin : g_f
            // R4
            unsel_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
               !rd_mask[rp*NF + f] |-> rd_data[rp*WW + f*FW +: FW] == '0);
            // R5
            single_fld_chk: assert property (@(posedge clk) disable iff (!rst_n)
               ($countones(rd_mask[rp*NF +: NF]) == 1 && rd_mask[rp*NF + f])
               |-> rd_fld[rp*FW +: FW] == rd_data[rp*WW + f*FW +: FW]);
         end
      end
   endgenerate

   // R7
   top_port_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(wr_mask[LP*NF +: NF]) == '1 && !$past(wr_fmode[LP])
       && rd_idx[IW-1:0] == $past(wr_idx[LP*IW +: IW]) && rd_mask[NF-1:0] == '1)
      |-> rd_data[WW-1:0] == $past(wr_data[LP*WW +: WW]));

   // R9
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(wr_mask) == '0 && $stable(rd_idx[IW-1:0])
       && $stable(rd_mask[NF-1:0]))
      |-> $stable(rd_data[WW-1:0]));
endmodule

bind crf_file crf_chk #(.NREGS(NREGS), .NF(NF), .FW(FW), .NRD(NRD), .NWR(NWR)) u_chk (
   .clk(clk), .rst_n(rst_n), .rd_idx(rd_idx), .rd_mask(rd_mask), .rd_data(rd_data),
   .rd_fld(rd_fld), .wr_idx(wr_idx), .wr_mask(wr_mask), .wr_data(wr_data),
   .wr_fmode(wr_fmode)
);

// File: tb/tb_crf_file.sv
`timescale 1ns/1ps
module tb_crf_file;
   localparam int NR = 16, NF = 8, FW = 4, NRD = 4, NWR = 3, WW = 32, IW = 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [NRD*IW-1:0] rd_idx = '0;
   logic [NRD*NF-1:0] rd_mask = '0;
   logic [NRD*WW-1:0] rd_data;
   logic [NRD*FW-1:0] rd_fld;
   logic [NWR*IW-1:0] wr_idx = '0;
   logic [NWR*NF-1:0] wr_mask = '0;
   logic [NWR*WW-1:0] wr_data = '0;
   logic [NWR-1:0]    wr_fmode = '0;

   int n_tests = 0, n_fail = 0;
   logic [WW-1:0] m [NR];

   always #5 clk = ~clk;

   crf_file dut (.*);

   function automatic logic [WW-1:0] expand(input logic [NF-1:0] mk);
      logic [WW-1:0] r = '0;
      for (int i = 0; i < NF; i++) if (mk[i]) r[i*FW +: FW] = '1;
      return r;
   endfunction

   function automatic logic [WW-1:0] eff(input logic [WW-1:0] d, input logic fm);
      return fm ? {NF{d[FW-1:0]}} : d;
   endfunction

   task automatic check(input string tag, input logic [WW-1:0] act, input logic [WW-1:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic set_wr(input int p, input int idx, input logic [NF-1:0] mk,
                         input logic [WW-1:0] d, input logic fm);
      wr_idx[p*IW +: IW]  = IW'(idx);
      wr_mask[p*NF +: NF] = mk;
      wr_data[p*WW +: WW] = d;
      wr_fmode[p]         = fm;
   endtask

   // commit model in port order, then advance one cycle and clear writes
   task automatic step;
      for (int p = 0; p < NWR; p++) begin
         logic [WW-1:0] e = expand(wr_mask[p*NF +: NF]);
         int i = int'(wr_idx[p*IW +: IW]);
         m[i] = (m[i] & ~e) | (eff(wr_data[p*WW +: WW], wr_fmode[p]) & e);
      end
      @(posedge clk);
      @(negedge clk);
      wr_mask = '0; wr_data = '0; wr_fmode = '0; wr_idx = '0;
      #1;
   endtask

   task automatic rd(input int p, input int idx, input logic [NF-1:0] mk, input string tag);
      logic [WW-1:0] ed;
      logic [FW-1:0] ef = '0;
      rd_idx[p*IW +: IW]  = IW'(idx);
      rd_mask[p*NF +: NF] = mk;
      #1;
      ed = m[idx] & expand(mk);
      for (int i = 0; i < NF; i++) ef |= ed[i*FW +: FW];
      check(tag, rd_data[p*WW +: WW], ed);
      check({tag, " fld"}, WW'(rd_fld[p*FW +: FW]), WW'(ef));
   endtask

   initial begin
      #2_000_000;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      for (int i = 0; i < NR; i++) m[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1: all registers zero after reset
      for (int i = 0; i < NR; i++) rd(i % NRD, i, 8'hFF, "R1 reset");

      // R2: full-word writes over every register, rotating ports
      for (int i = 0; i < NR; i++) begin
         set_wr(i % NWR, i, 8'hFF, 32'h9E37_79B9 * (i + 1), 1'b0);
         step();
      end
      for (int i = 0; i < NR; i++) rd(i % NRD, i, 8'hFF, "R2 word readback");

      // R3: single-field writes, every register and field
      for (int i = 0; i < NR; i++)
         for (int f = 0; f < NF; f++) begin
            set_wr((i + f) % NWR, i, NF'(1) << f, {NF{4'(i ^ f ^ 4'h9)}}, 1'b0);
            step();
            rd(0, i, 8'hFF, "R3 field write keeps others");
         end

      // R4/R5: every single-field read mask, plus multi-hot masks
      for (int i = 0; i < NR; i++) begin
         for (int f = 0; f < NF; f++) rd(f % NRD, i, NF'(1) << f, "R4/R5 single mask");
         rd(1, i, 8'h81, "R4/R5 multi mask");
         rd(2, i, 8'h00, "R4 empty mask");
      end

      // R6: broadcast field mode, upper data bits ignored
      set_wr(1, 5, 8'h5A, 32'hFFFF_FFF3, 1'b1);
      step();
      rd(0, 5, 8'hFF, "R6 broadcast");
      set_wr(0, 6, 8'h80, 32'h0000_000C, 1'b1);
      step();
      rd(3, 6, 8'h80, "R6 top field");

      // R7: same field collisions and merges
      set_wr(0, 9, 8'h01, 32'h1, 1'b0);
      set_wr(1, 9, 8'h01, 32'h2, 1'b0);
      set_wr(2, 9, 8'h01, 32'h3, 1'b0);
      step();
      check("R7 port2 wins", rd_data[WW-1:0] & 0, 0);
      rd(0, 9, 8'h01, "R7 port2 wins");
      check("R7 port2 value", m[9][3:0], 4'h3);
      set_wr(0, 10, 8'h03, 32'h0000_00AA, 1'b0);
      set_wr(1, 10, 8'h02, 32'h0000_00B0, 1'b0);
      set_wr(2, 10, 8'hF0, 32'h1234_0000, 1'b0);
      step();
      rd(1, 10, 8'hFF, "R7 merge");
      check("R7 merge value", m[10] & 32'hFFFF_00FF, 32'h1234_00BA);

      // R8: read in write cycle returns old value
      set_wr(2, 12, 8'hFF, 32'hDEAD_BEEF, 1'b0);
      rd(2, 12, 8'hFF, "R8 old value");
      step();
      rd(2, 12, 8'hFF, "R8 new value");

      // R9: zero mask writes nothing
      for (int i = 0; i < NR; i++) begin
         set_wr(i % NWR, i, 8'h00, 32'hFFFF_FFFF, i[0]);
         step();
      end
      for (int i = 0; i < NR; i++) rd(i % NRD, i, 8'hFF, "R9 no change");

      // R10: four independent read ports in one cycle
      for (int i = 0; i < NR; i++) begin
         for (int p = 0; p < NRD; p++) begin
            rd_idx[p*IW +: IW]  = IW'((i + 5 * p) % NR);
            rd_mask[p*NF +: NF] = 8'hFF >> p;
         end
         #1;
         for (int p = 0; p < NRD; p++)
            check("R10 parallel read", rd_data[p*WW +: WW],
                  m[(i + 5 * p) % NR] & expand(8'hFF >> p));
      end

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule